// File: doc/BRIEF.md
# In-Order Retirement Buffer

This block keeps the program order of in-flight instructions in an out-of-order core. The dispatcher claims one slot per instruction, in order, storing the physical register that the instruction's destination mapping displaced. The block returns the slot index, and the execution side later uses that index to mark the instruction finished.

Retirement runs by itself every cycle. Up to two slots leave from the oldest end, and only while they are finished. A finished young instruction waits behind an unfinished older one. Each retiring slot presents its displaced physical register to the rename free list. A flush discards every slot in one cycle and releases no registers.

Top module: `rob_commit`

## Requirements
- R1: After reset the buffer is empty (`rob_empty`=1), `alloc_ready`=1, `alloc_idx`=0 and both retire outputs are 0.
- R2: Each accepted allocation (`alloc_valid` and `alloc_ready`) takes slot `alloc_idx`. The following allocation gets the next index, which wraps from DEPTH-1 to 0.
- R3: With DEPTH slots occupied, `alloc_ready` is 0. A request made then is dropped: `alloc_idx` does not move, and the register it carried never appears at retirement.
- R4: A newly allocated slot is unfinished, even if its index was marked finished in an earlier use. It does not retire until a writeback names it.
- R5: Retirement is strictly oldest-first. A finished slot does not retire while any older slot is unfinished, and nothing retires from an empty buffer.
- R6: When the two oldest slots are both finished, both retire in the same cycle. Port 0 carries the older slot and port 1 the younger.
- R7: Each retire port presents the register stored with its slot at allocation (`ret0_preg`, `ret1_preg`).
- R8: Port 1 is valid only together with port 0. When only the oldest slot is finished, just one slot retires.
- R9: `flush` suppresses both retire ports in its cycle. From the next cycle the buffer is empty and the next allocation gets index 0.
- R10: Retirement of two slots continues correctly across the wrap from index DEPTH-1 to index 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Discard all slots |
| alloc_valid | input | 1 | Dispatch requests a slot |
| alloc_preg | input | PREG_W | Displaced physical register for the new slot |
| alloc_ready | output | 1 | A slot is free and no flush is in progress |
| alloc_idx | output | $clog2(DEPTH) | Index the next allocation takes |
| wb_valid | input | 1 | Mark a slot finished |
| wb_idx | input | $clog2(DEPTH) | Slot to mark |
| rob_empty | output | 1 | No slot occupied |
| ret0_valid | output | 1 | Oldest slot retires this cycle |
| ret0_preg | output | PREG_W | Register released by port 0 |
| ret1_valid | output | 1 | Second oldest slot retires this cycle |
| ret1_preg | output | PREG_W | Register released by port 1 |

## Verification
The bench finishes a younger instruction before an older one. A design that ignores order would free the young register early and corrupt the free list. It fills the buffer and pushes one more request. A design that overwrites the oldest slot would later release a register that was never freed. It retires a pair across the index wrap, where a head pointer advanced without modular wrap would stall or read a stale slot. It also flushes with a finished slot at the head, which a design that does not gate retirement on flush would leak. Finally it reuses an index whose finished flag is stale, where a design that does not clear the flag on allocation would retire at once.

// File: rtl/rob_commit.sv
module rob_commit #(
  parameter int DEPTH  = 16,
  parameter int PREG_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              flush,
  input  logic              alloc_valid,
  input  logic [PREG_W-1:0] alloc_preg,
  output logic              alloc_ready,
  output logic [$clog2(DEPTH)-1:0] alloc_idx,
  input  logic              wb_valid,
  input  logic [$clog2(DEPTH)-1:0] wb_idx,
  output logic              rob_empty,
  output logic              ret0_valid,
  output logic [PREG_W-1:0] ret0_preg,
  output logic              ret1_valid,
  output logic [PREG_W-1:0] ret1_preg
);
  localparam int IDX_W = $clog2(DEPTH);
  localparam logic [IDX_W:0] FULL_CNT = (IDX_W+1)'(DEPTH);

  logic [IDX_W:0]    head_q, tail_q, used;
  logic [PREG_W-1:0] preg_q [DEPTH];
  logic [DEPTH-1:0]  done_q;
  logic [IDX_W-1:0]  head_idx, head_nxt, tail_idx;
  logic              alloc_fire;

  assign used        = tail_q - head_q;
  assign rob_empty   = (used == '0);
  assign alloc_ready = (used != FULL_CNT) && !flush;
  assign alloc_fire  = alloc_valid && alloc_ready;
  assign head_idx    = head_q[IDX_W-1:0];
  assign head_nxt    = head_idx + 1'b1;
  assign tail_idx    = tail_q[IDX_W-1:0];
  assign alloc_idx   = tail_idx;

  assign ret0_valid = !flush && !rob_empty && done_q[head_idx];
  assign ret1_valid = ret0_valid && (used > (IDX_W+1)'(1)) && done_q[head_nxt];
  assign ret0_preg  = preg_q[head_idx];
  assign ret1_preg  = preg_q[head_nxt];

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      head_q <= '0;
      tail_q <= '0;
    end else begin
      head_q <= head_q + (IDX_W+1)'(ret0_valid) + (IDX_W+1)'(ret1_valid);
      if (alloc_fire) tail_q <= tail_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      done_q <= '0;
    end else begin
      if (wb_valid)   done_q[wb_idx]   <= 1'b1;
      if (alloc_fire) done_q[tail_idx] <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (alloc_fire) preg_q[tail_idx] <= alloc_preg;
  end
endmodule

module rob_commit_chk #(
  parameter int IDX_W = 4
) (
  input logic             clk,
  input logic             rst_n,
  input logic             flush,
  input logic             alloc_valid,
  input logic             alloc_ready,
  input logic [IDX_W-1:0] alloc_idx,
  input logic             rob_empty,
  input logic             ret0_valid,
  input logic             ret1_valid
);
  AST_IDX_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && alloc_ready) |=> alloc_idx == IDX_W'($past(alloc_idx) + 1'b1)); // R2
  AST_FULL_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (!alloc_ready && !flush) |-> !rob_empty); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (alloc_valid && !alloc_ready && !flush) |=> $stable(alloc_idx)); // R3
  AST_EMPTY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    rob_empty |-> !ret0_valid); // R5
  AST_SLOT_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    ret1_valid |-> ret0_valid); // R8
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (rob_empty && alloc_idx == '0)); // R9
endmodule

bind rob_commit rob_commit_chk #(.IDX_W(IDX_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
  .alloc_ready(alloc_ready), .alloc_idx(alloc_idx), .rob_empty(rob_empty),
  .ret0_valid(ret0_valid), .ret1_valid(ret1_valid)
);

// File: tb/rob_commit_bench.sv
`timescale 1ns/1ps
module rob_commit_bench;
  localparam int DEPTH = 8;
  localparam int PW    = 6;
  localparam int IW    = 3;

  logic clk = 1'b0, rst_n = 1'b0, flush = 1'b0;
  logic alloc_valid = 1'b0, wb_valid = 1'b0;
  logic [PW-1:0] alloc_preg = '0;
  logic [IW-1:0] wb_idx = '0;
  logic alloc_ready, rob_empty, ret0_valid, ret1_valid;
  logic [IW-1:0] alloc_idx;
  logic [PW-1:0] ret0_preg, ret1_preg;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  rob_commit #(.DEPTH(DEPTH), .PREG_W(PW)) u_rob_commit (
    .clk(clk), .rst_n(rst_n), .flush(flush), .alloc_valid(alloc_valid),
    .alloc_preg(alloc_preg), .alloc_ready(alloc_ready), .alloc_idx(alloc_idx),
    .wb_valid(wb_valid), .wb_idx(wb_idx), .rob_empty(rob_empty),
    .ret0_valid(ret0_valid), .ret0_preg(ret0_preg),
    .ret1_valid(ret1_valid), .ret1_preg(ret1_preg)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // inputs driven after a negedge, released just after the following posedge
  task automatic cyc();
    @(posedge clk); #1;
    alloc_valid = 1'b0; wb_valid = 1'b0; flush = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_alloc(input int preg, input int exp_idx, input string req);
    chk(req, alloc_idx, exp_idx);
    alloc_valid = 1'b1; alloc_preg = PW'(preg);
    cyc();
  endtask

  task automatic do_wb(input int idx);
    wb_valid = 1'b1; wb_idx = IW'(idx);
    cyc();
  endtask

  task automatic expect_ret(input string req, input bit v0, input int p0, input bit v1, input int p1);
    chk({req, " ret0_valid"}, ret0_valid, v0);
    if (v0) chk({req, " ret0_preg"}, ret0_preg, p0);
    chk({req, " ret1_valid"}, ret1_valid, v1);
    if (v1) chk({req, " ret1_preg"}, ret1_preg, p1);
  endtask

  task automatic t_reset();
    chk("R1 empty", rob_empty, 1);
    chk("R1 ready", alloc_ready, 1);
    chk("R1 idx", alloc_idx, 0);
    expect_ret("R1", 0, 0, 0, 0);
  endtask

  task automatic t_order();
    do_alloc(10, 0, "R2");
    do_alloc(11, 1, "R2");
    do_alloc(12, 2, "R2");
    expect_ret("R4", 0, 0, 0, 0);
    do_wb(1);
    expect_ret("R5", 0, 0, 0, 0);
    do_wb(0);
    expect_ret("R6 R7", 1, 10, 1, 11);
    cyc();
    expect_ret("R5", 0, 0, 0, 0);
    do_wb(2);
    expect_ret("R8", 1, 12, 0, 0);
    cyc();
    chk("R5 empty", rob_empty, 1);
  endtask

  task automatic t_full_wrap();
    for (int i = 0; i < DEPTH; i++) do_alloc(20 + i, (3 + i) % DEPTH, "R2 wrap");
    chk("R3 ready", alloc_ready, 0);
    alloc_valid = 1'b1; alloc_preg = PW'(63);
    cyc();
    chk("R3 idx held", alloc_idx, 3);
    for (int i = 1; i < DEPTH; i++) begin
      do_wb((3 + i) % DEPTH);
      expect_ret("R5", 0, 0, 0, 0);
    end
    do_wb(3);
    for (int k = 0; k < DEPTH / 2; k++) begin
      expect_ret((k == 2) ? "R10" : "R6", 1, 20 + 2 * k, 1, 21 + 2 * k);
      cyc();
    end
    chk("R3 dropped", ret0_valid, 0);
    chk("R3 empty", rob_empty, 1);
  endtask

  task automatic t_flush();
    do_alloc(30, 3, "R2");
    do_alloc(31, 4, "R2");
    do_wb(3);
    expect_ret("R7", 1, 30, 0, 0);
    flush = 1'b1;
    #1;
    expect_ret("R9", 0, 0, 0, 0);
    @(negedge clk);
    flush = 1'b0;
    @(negedge clk);
    cyc();
    chk("R9 empty", rob_empty, 1);
    chk("R9 idx", alloc_idx, 0);
    expect_ret("R9", 0, 0, 0, 0);
    do_alloc(40, 0, "R9");
    expect_ret("R4 stale", 0, 0, 0, 0);
    do_wb(0);
    expect_ret("R4", 1, 40, 0, 0);
    cyc();
  endtask

  initial begin
    fork
      begin
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_order();
        t_full_wrap();
        t_flush();
      end
      begin
        repeat (5000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule